// File: doc/BRIEF.md
# Vertical-Sync Aligned Shadow Register Bank

This block keeps two copies of a small group of control bytes for a video packet path: the quantiser setup, the line-count and output-mode byte, the upper and lower per-line byte budgets, and the clock and polarity byte. The host writes new values into a staging copy over a simple register bus. The packetiser and compressor see only the active copy, so they never pick up a half-written set of values.

To commit the staged values, the host writes 1 to a request bit. At the next falling edge of vertical sync, all staged bytes move into the active copy in the same clock cycle. A header-marker output then drops from 1 to 0, and the packetiser copies it into bit 7 of every packet header, so a header of 0x80 becomes 0x00. The marker stays low until the host writes 0 to the request bit. Vertical sync is asynchronous to the block clock. It passes through a two-flop synchroniser, and a one-cycle falling-edge pulse is derived from the synchronised signal.

Top module: `vsync_shadow_regs`

## Requirements
- R1: After reset, the active values read back as quantiser 0x63 (address 0), line/mode 0x07 (address 1), upper budget 0x73 (address 2), lower budget 0x73 (address 3) and polarity 0x4A (address 4), and the header marker is 1.
- R2: A write to addresses 0 to 4 changes only the staging copy. The active outputs and the read-back value stay the same until an update takes place.
- R3: When the request is armed, every staged byte moves into the active copy together, in one clock. The new values are visible on the third rising clock edge after the vertical-sync input falls, and not before that edge.
- R4: A falling vertical-sync edge with no armed request leaves the active copy unchanged. A rising edge never causes an update.
- R5: Writing 1 to bit 0 of address 5 arms the request. After the update, the header marker is 0 and stays 0 until bit 0 of address 5 is written with 0, which returns it to 1.
- R6: Staged writes made after an update stay staged through later falling edges until the request is armed again.
- R7: Two request writes before one falling edge give exactly one update. The next falling edge, with no new request, commits nothing.
- R8: Address 5 is write-only and reads as 0x00. Addresses 6 and 7 also read as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Active value at rd_addr (combinational) |
| vsync_in | input | 1 | Asynchronous vertical sync |
| quant_o | output | 8 | Active quantiser control |
| line_mode_o | output | 8 | Active line-count and mode byte |
| budget_hi_o | output | 8 | Active upper per-line byte budget |
| budget_lo_o | output | 8 | Active lower per-line byte budget |
| polarity_o | output | 8 | Active clock and polarity byte |
| hdr_bit7_o | output | 1 | Packet-header bit 7: 1 normally, 0 after an update until the request is cleared |

## Verification
The bench first loads staged values and toggles vertical sync with no request. Any change in that case would show that staged writes leak through or that edges fire without a request. It then arms a request and checks the outputs after two clocks and again after three clocks following the sync fall. This shows whether the three-edge latency is exact and whether all five bytes move together. Further sequences write staged values after an update and send extra sync edges, which separates a request that is consumed once from one that keeps re-triggering. A double request shows whether a second arming write creates a second update. A final sequence clears and re-arms the request to confirm that the header marker follows the request bit.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 3;
    localparam int NUM_SYNC = 5;
    localparam int REQ_ADDR = NUM_SYNC;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } reg_wr_t;

    typedef logic [NUM_SYNC-1:0][DATA_W-1:0] bank_t;

    function automatic logic [DATA_W-1:0] reset_value(input int idx);
        case (idx)
            0:       return DATA_W'(8'h63);
            1:       return DATA_W'(8'h07);
            2:       return DATA_W'(8'h73);
            3:       return DATA_W'(8'h73);
            4:       return DATA_W'(8'h4A);
            default: return '0;
        endcase
    endfunction

    function automatic logic hits(input reg_wr_t w, input int idx);
        return w.en && (w.addr == ADDR_W'(idx));
    endfunction

endpackage

// File: rtl/vsync_fall_detect.sv
module vsync_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic vsync_in,
    output logic fall_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= vsync_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign fall_o = prev_q & ~sync_q;

    // R3
    fall_single_chk: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/update_ctrl.sv
module update_ctrl
    import shadow_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reg_wr_t wr,
    input  logic    fall,
    output logic    load_o,
    output logic    hdr_bit7_o
);
    logic armed_q, done_q;
    logic req_wr, req_set, req_clr;

    assign req_wr  = hits(wr, REQ_ADDR);
    assign req_set = req_wr &  wr.data[0];
    assign req_clr = req_wr & ~wr.data[0];
    assign load_o  = armed_q & fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            if (req_wr)
                armed_q <= wr.data[0];
            else if (load_o)
                armed_q <= 1'b0;

            if (req_clr)
                done_q <= 1'b0;
            else if (load_o)
                done_q <= 1'b1;
        end
    end

    assign hdr_bit7_o = ~done_q;

    // R5
    mark_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (load_o && !req_clr) |=> !hdr_bit7_o);

    // R5
    mark_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!hdr_bit7_o && !req_clr) |=> !hdr_bit7_o);

    // R5
    mark_clear_chk: assert property (@(posedge clk) disable iff (rst)
        req_clr |=> hdr_bit7_o);

    // R7
    one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        (load_o && !req_set) |=> !load_o);

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
    import shadow_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  reg_wr_t wr,
    input  logic    load,
    output bank_t   active_o
);
    bank_t staged_q;
    bank_t active_q;

    for (genvar i = 0; i < NUM_SYNC; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                staged_q[i] <= reset_value(i);
                active_q[i] <= reset_value(i);
            end else begin
                if (hits(wr, i))
                    staged_q[i] <= wr.data;
                if (load)
                    active_q[i] <= staged_q[i];
            end
        end
    end

    assign active_o = active_q;

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(active_q));

    // R3
    commit_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (active_q == $past(staged_q)));

endmodule

// File: rtl/vsync_shadow_regs.sv
module vsync_shadow_regs
    import shadow_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    input  logic       vsync_in,
    output logic [7:0] quant_o,
    output logic [7:0] line_mode_o,
    output logic [7:0] budget_hi_o,
    output logic [7:0] budget_lo_o,
    output logic [7:0] polarity_o,
    output logic       hdr_bit7_o
);
    reg_wr_t wr;
    logic    fall, load;
    bank_t   active;

    assign wr = '{en: wr_en, addr: wr_addr, data: wr_data};

    vsync_fall_detect u_edge (
        .clk(clk), .rst(rst), .vsync_in(vsync_in), .fall_o(fall)
    );

    update_ctrl u_ctrl (
        .clk(clk), .rst(rst), .wr(wr), .fall(fall),
        .load_o(load), .hdr_bit7_o(hdr_bit7_o)
    );

    shadow_bank u_bank (
        .clk(clk), .rst(rst), .wr(wr), .load(load), .active_o(active)
    );

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SYNC; i++)
            if (rd_addr == ADDR_W'(i))
                rd_data = active[i];
    end

    assign quant_o     = active[0];
    assign line_mode_o = active[1];
    assign budget_hi_o = active[2];
    assign budget_lo_o = active[3];
    assign polarity_o  = active[4];

    // R8
    req_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_addr >= ADDR_W'(NUM_SYNC)) |-> (rd_data == '0));

endmodule

// File: tb/tb_vsync_shadow_regs.sv
module tb_vsync_shadow_regs;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       vsync_in = 1'b0;
    logic [7:0] quant_o, line_mode_o, budget_hi_o, budget_lo_o, polarity_o;
    logic       hdr_bit7_o;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    vsync_shadow_regs dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .vsync_in(vsync_in),
        .quant_o(quant_o), .line_mode_o(line_mode_o), .budget_hi_o(budget_hi_o),
        .budget_lo_o(budget_lo_o), .polarity_o(polarity_o), .hdr_bit7_o(hdr_bit7_o)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [7:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic vs_pulse();
        @(negedge clk); vsync_in = 1'b1;
        wait_n(5);
        vsync_in = 1'b0;
        wait_n(5);
    endtask

    task automatic check_all(input string req, input logic [7:0] q, input logic [7:0] l,
                             input logic [7:0] h, input logic [7:0] lo, input logic [7:0] p);
        check(req, quant_o, q);
        check(req, line_mode_o, l);
        check(req, budget_hi_o, h);
        check(req, budget_lo_o, lo);
        check(req, polarity_o, p);
    endtask

    task automatic t_reset();
        rd_check("R1 quant", 3'd0, 8'h63);
        rd_check("R1 line", 3'd1, 8'h07);
        rd_check("R1 bhi", 3'd2, 8'h73);
        rd_check("R1 blo", 3'd3, 8'h73);
        rd_check("R1 pol", 3'd4, 8'h4A);
        check_all("R1 outputs", 8'h63, 8'h07, 8'h73, 8'h73, 8'h4A);
        check("R1 hdr", {7'd0, hdr_bit7_o}, 8'h01);
        rd_check("R8 req reads zero", 3'd5, 8'h00);
        rd_check("R8 addr6", 3'd6, 8'h00);
    endtask

    task automatic t_staged_hold();
        wr(3'd0, 8'h11); wr(3'd1, 8'h22); wr(3'd2, 8'h33);
        wr(3'd3, 8'h44); wr(3'd4, 8'h55);
        check_all("R2 staged only", 8'h63, 8'h07, 8'h73, 8'h73, 8'h4A);
        rd_check("R2 readback", 3'd0, 8'h63);
        vs_pulse();
        check_all("R4 no request", 8'h63, 8'h07, 8'h73, 8'h73, 8'h4A);
        check("R4 hdr", {7'd0, hdr_bit7_o}, 8'h01);
    endtask

    task automatic t_update();
        @(negedge clk); vsync_in = 1'b1;
        wait_n(5);
        wr(3'd5, 8'h01);
        rd_check("R8 req armed reads zero", 3'd5, 8'h00);
        check_all("R3 armed no edge", 8'h63, 8'h07, 8'h73, 8'h73, 8'h4A);
        vsync_in = 1'b0;
        wait_n(2);
        check("R3 not before third edge", quant_o, 8'h63);
        check("R5 hdr before", {7'd0, hdr_bit7_o}, 8'h01);
        wait_n(1);
        check_all("R3 committed", 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
        rd_check("R3 readback", 3'd4, 8'h55);
        check("R5 hdr low", {7'd0, hdr_bit7_o}, 8'h00);
    endtask

    task automatic t_hold_after();
        wr(3'd0, 8'hA0);
        vs_pulse();
        check("R6 stays staged", quant_o, 8'h11);
        check("R5 hdr held", {7'd0, hdr_bit7_o}, 8'h00);
        wr(3'd5, 8'h00);
        wait_n(1);
        check("R5 hdr back", {7'd0, hdr_bit7_o}, 8'h01);
        wr(3'd5, 8'h01);
        vs_pulse();
        check("R6 next request", quant_o, 8'hA0);
        check("R6 others kept", polarity_o, 8'h55);
        check("R5 hdr low again", {7'd0, hdr_bit7_o}, 8'h00);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_double();
        wr(3'd2, 8'hB1);
        wr(3'd5, 8'h01);
        wr(3'd5, 8'h01);
        vs_pulse();
        check("R7 one update", budget_hi_o, 8'hB1);
        wr(3'd2, 8'hC2);
        vs_pulse();
        check("R7 no second update", budget_hi_o, 8'hB1);
        wr(3'd5, 8'h00);
        vs_pulse();
        check("R4 cleared request", budget_hi_o, 8'hB1);
        check("R5 hdr after clear", {7'd0, hdr_bit7_o}, 8'h01);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog got=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        t_reset();
        t_staged_hold();
        t_update();
        t_hold_after();
        t_double();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule